// File: doc/BRIEF.md
# Register Window Occupancy Tracker

This block tracks how the windows of a windowed register file are in use. It holds four small occupancy counters: windows free for a save, windows holding data that a restore can reach, windows that belong to another context, and windows already cleaned. It also holds a six-bit trap-vector selector and the current-window pointer. A pipeline issues one window operation per cycle: save, restore, flush, a saved notification or a restored notification. The block then either moves the pointer and adjusts the counters, or raises a trap. A spill, fill or clean-window trap carries a trap type computed from the selector.

Software reads and writes every counter, the selector and the pointer through one write port. The pointer is shown to software in reversed numbering: the visible value is N-1 minus the internal index. A write of an out-of-range pointer value is first reduced modulo N. Trap-level bookkeeping and the register storage itself are handled elsewhere.

Top module: `win_state_unit`

## Requirements
- R1: After reset (synchronous, active high): free = N-2, reachable = 0, foreign = 0, clean = N-1, selector = 0, visible pointer = N-1, and no trap is flagged.
- R2: A save (op_code 1) while the free counter is 0 raises a spill trap and leaves all state unchanged. This check takes priority over the clean-window check.
- R3: A save while the free counter is nonzero and the clean counter equals the reachable counter raises a clean-window trap of type 0x024 and leaves all state unchanged.
- R4: A save that does not trap increments the visible pointer modulo N, decrements the free counter and increments the reachable counter.
- R5: A restore (op_code 2) while the reachable counter is 0 raises a fill trap and changes nothing. Otherwise it decrements the visible pointer modulo N, decrements the reachable counter and increments the free counter.
- R6: The spill type is 0x080 and the fill type is 0x0C0, each ORed with a field taken from the selector. If the foreign counter is nonzero, the field is 0x20 OR (selector bits 5:3 shifted left by 2). Otherwise it is selector bits 2:0 shifted left by 2.
- R7: A flush (op_code 3) raises a spill trap unless the free counter equals N-2. In either case it changes no counter.
- R8: A saved notification (op_code 4) increments the free counter. It then decrements the foreign counter if that counter is nonzero, and the reachable counter otherwise.
- R9: A restored notification (op_code 5) increments the reachable counter. It increments the clean counter only while that counter is below N-1. It then decrements the foreign counter if that counter is nonzero, and the free counter otherwise.
- R10: A write (wr_en) loads the target chosen by wr_sel: 0 free, 1 reachable, 2 foreign, 3 clean, 4 selector, 5 pointer. A pointer write v is reduced modulo N and then shows as visible pointer v mod N.
- R11: trap_valid is high only in the cycle after an executed operation that traps. When wr_en and op_valid are both high, only the write takes effect, and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 3 | 0 none, 1 save, 2 restore, 3 flush, 4 saved, 5 restored |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 3 | Write target (see R10) |
| wr_data | input | 8 | Write value |
| cansave | output | $clog2(N) | Free-window counter |
| canrestore | output | $clog2(N) | Reachable-window counter |
| otherwin | output | $clog2(N) | Foreign-window counter |
| cleanwin | output | $clog2(N) | Clean-window counter |
| wstate | output | 6 | Trap-vector selector |
| cwp_sw | output | $clog2(N) | Pointer in software numbering |
| trap_valid | output | 1 | Trap raised by the previous operation |
| trap_type | output | 9 | Trap type, 0 when no trap |

## Verification
The bench targets the following corner cases:
- Pointer wrap in both directions. A design with the wrong direction or modulus shows the visible pointer stepping the wrong way, or leaving the 0..N-1 range, at 7→0 and 0→7.
- The clean counter at its ceiling during a restored notification. A design that does not saturate wraps the counter to 0.
- Selection of the foreign versus normal selector field. Swapping the fields gives 0x0AC and 0x088 the wrong way round.
- A pointer write of 13 with N = 8. Without the modulo reduction the pointer takes a wrong window.
- An operation issued together with a write. If the operation is not suppressed, a spurious fill trap appears.

// File: rtl/wsu_pkg.sv
package wsu_pkg;

    localparam int WS_W = 6;
    localparam int TT_W = 9;
    localparam int WR_W = 8;

    localparam logic [TT_W-1:0] SPILL_BASE = 9'h080;
    localparam logic [TT_W-1:0] FILL_BASE  = 9'h0C0;
    localparam logic [TT_W-1:0] CLEAN_TT   = 9'h024;
    localparam logic [TT_W-1:0] OTHER_FLAG = 9'h020;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_SAVE     = 3'd1,
        OP_RESTORE  = 3'd2,
        OP_FLUSH    = 3'd3,
        OP_SAVED    = 3'd4,
        OP_RESTORED = 3'd5
    } wsu_op_e;

    typedef enum logic [2:0] {
        SEL_FREE   = 3'd0,
        SEL_REACH  = 3'd1,
        SEL_OTHER  = 3'd2,
        SEL_CLEAN  = 3'd3,
        SEL_WSTATE = 3'd4,
        SEL_CWP    = 3'd5
    } wsu_sel_e;

    typedef enum logic [1:0] {
        TK_NONE,
        TK_SPILL,
        TK_FILL,
        TK_CLEAN
    } trap_kind_e;

    // Per-cycle actions decided by the evaluator, independent of counter width
    typedef struct packed {
        logic       cwp_inc;
        logic       cwp_dec;
        logic       free_inc;
        logic       free_dec;
        logic       reach_inc;
        logic       reach_dec;
        logic       other_dec;
        logic       clean_inc;
        trap_kind_e trap;
    } wsu_act_s;

    // Field picked from the selector: foreign half when other windows exist
    function automatic logic [TT_W-1:0] sel_field(input logic [WS_W-1:0] ws,
                                                  input logic other_nz);
        if (other_nz)
            return OTHER_FLAG | TT_W'({ws[5:3], 2'b00});
        else
            return TT_W'({ws[2:0], 2'b00});
    endfunction

endpackage

// File: rtl/wsu_op_eval.sv
module wsu_op_eval
    import wsu_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic          go,
    input  wsu_op_e       op,
    input  logic [CW-1:0] free_cnt,
    input  logic [CW-1:0] reach_cnt,
    input  logic [CW-1:0] other_cnt,
    input  logic [CW-1:0] clean_cnt,
    output wsu_act_s      act
);
    localparam logic [CW-1:0] FLUSH_OK  = CW'(NWIN - 2);
    localparam logic [CW-1:0] CLEAN_TOP = CW'(NWIN - 1);

    logic other_nz;
    assign other_nz = (other_cnt != '0);

    always_comb begin
        act      = '0;
        act.trap = TK_NONE;
        if (go) begin
            case (op)
                OP_SAVE: begin
                    if (free_cnt == '0)
                        act.trap = TK_SPILL;
                    else if (clean_cnt == reach_cnt)
                        act.trap = TK_CLEAN;
                    else begin
                        act.cwp_dec   = 1'b1;
                        act.free_dec  = 1'b1;
                        act.reach_inc = 1'b1;
                    end
                end
                OP_RESTORE: begin
                    if (reach_cnt == '0)
                        act.trap = TK_FILL;
                    else begin
                        act.cwp_inc   = 1'b1;
                        act.reach_dec = 1'b1;
                        act.free_inc  = 1'b1;
                    end
                end
                OP_FLUSH: begin
                    if (free_cnt != FLUSH_OK)
                        act.trap = TK_SPILL;
                end
                OP_SAVED: begin
                    act.free_inc  = 1'b1;
                    act.other_dec = other_nz;
                    act.reach_dec = !other_nz;
                end
                OP_RESTORED: begin
                    act.reach_inc = 1'b1;
                    act.clean_inc = (clean_cnt < CLEAN_TOP);
                    act.other_dec = other_nz;
                    act.free_dec  = !other_nz;
                end
                default: act = act;
            endcase
        end
    end
endmodule

// File: rtl/wsu_trap_enc.sv
module wsu_trap_enc
    import wsu_pkg::*;
(
    input  trap_kind_e       kind,
    input  logic [WS_W-1:0]  ws,
    input  logic             other_nz,
    output logic [TT_W-1:0]  tt
);
    logic [TT_W-1:0] field;
    assign field = sel_field(ws, other_nz);

    always_comb begin
        case (kind)
            TK_SPILL: tt = SPILL_BASE | field;
            TK_FILL:  tt = FILL_BASE | field;
            TK_CLEAN: tt = CLEAN_TT;
            default:  tt = '0;
        endcase
    end
endmodule

// File: rtl/wsu_cwp_map.sv
module wsu_cwp_map
    import wsu_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic [CW-1:0]   cwp_int,
    input  logic [WR_W-1:0] wr_val,
    output logic [CW-1:0]   cwp_view,
    output logic [CW-1:0]   cwp_from_wr
);
    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    assign cwp_view = LAST - cwp_int;

    always_comb begin
        logic [31:0] red;
        red         = 32'(wr_val) % 32'(NWIN);
        cwp_from_wr = LAST - CW'(red);
    end
endmodule

// File: rtl/win_state_unit.sv
module win_state_unit
    import wsu_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [WR_W-1:0] wr_data,
    output logic [CW-1:0]   cansave,
    output logic [CW-1:0]   canrestore,
    output logic [CW-1:0]   otherwin,
    output logic [CW-1:0]   cleanwin,
    output logic [WS_W-1:0] wstate,
    output logic [CW-1:0]   cwp_sw,
    output logic            trap_valid,
    output logic [TT_W-1:0] trap_type
);
    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    logic [CW-1:0]   free_q, reach_q, other_q, clean_q, cwp_q;
    logic [WS_W-1:0] ws_q;
    logic            tv_q;
    logic [TT_W-1:0] tt_q;

    wsu_act_s        act;
    logic [TT_W-1:0] tt_c;
    logic [CW-1:0]   cwp_wr_int;
    logic            go;

    assign go = op_valid && !wr_en;

    wsu_op_eval #(.NWIN(NWIN)) u_eval (
        .go        (go),
        .op        (wsu_op_e'(op_code)),
        .free_cnt  (free_q),
        .reach_cnt (reach_q),
        .other_cnt (other_q),
        .clean_cnt (clean_q),
        .act       (act)
    );

    wsu_trap_enc u_enc (
        .kind     (act.trap),
        .ws       (ws_q),
        .other_nz (other_q != '0),
        .tt       (tt_c)
    );

    wsu_cwp_map #(.NWIN(NWIN)) u_map (
        .cwp_int     (cwp_q),
        .wr_val      (wr_data),
        .cwp_view    (cwp_sw),
        .cwp_from_wr (cwp_wr_int)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q  <= CW'(NWIN - 2);
            reach_q <= '0;
            other_q <= '0;
            clean_q <= LAST;
            ws_q    <= '0;
            cwp_q   <= '0;
            tv_q    <= 1'b0;
            tt_q    <= '0;
        end else begin
            tv_q <= (act.trap != TK_NONE);
            tt_q <= tt_c;
            if (wr_en) begin
                case (wsu_sel_e'(wr_sel))
                    SEL_FREE:   free_q  <= wr_data[CW-1:0];
                    SEL_REACH:  reach_q <= wr_data[CW-1:0];
                    SEL_OTHER:  other_q <= wr_data[CW-1:0];
                    SEL_CLEAN:  clean_q <= wr_data[CW-1:0];
                    SEL_WSTATE: ws_q    <= wr_data[WS_W-1:0];
                    SEL_CWP:    cwp_q   <= cwp_wr_int;
                    default:    ws_q    <= ws_q;
                endcase
            end else begin
                if (act.free_inc)       free_q <= free_q + 1'b1;
                else if (act.free_dec)  free_q <= free_q - 1'b1;
                if (act.reach_inc)      reach_q <= reach_q + 1'b1;
                else if (act.reach_dec) reach_q <= reach_q - 1'b1;
                if (act.other_dec)      other_q <= other_q - 1'b1;
                if (act.clean_inc)      clean_q <= clean_q + 1'b1;
                if (act.cwp_inc)        cwp_q <= (cwp_q == LAST) ? '0 : cwp_q + 1'b1;
                else if (act.cwp_dec)   cwp_q <= (cwp_q == '0) ? LAST : cwp_q - 1'b1;
            end
        end
    end

    assign cansave    = free_q;
    assign canrestore = reach_q;
    assign otherwin   = other_q;
    assign cleanwin   = clean_q;
    assign wstate     = ws_q;
    assign trap_valid = tv_q;
    assign trap_type  = tt_q;
endmodule

// File: rtl/wsu_checker.sv
module wsu_checker #(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid,
    input logic [2:0]    op_code,
    input logic          wr_en,
    input logic [CW-1:0] cansave,
    input logic [CW-1:0] canrestore,
    input logic [CW-1:0] cleanwin,
    input logic [CW-1:0] cwp_sw,
    input logic          trap_valid,
    input logic [8:0]    trap_type
);
    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    logic go;
    assign go = op_valid && !wr_en;

    a_r2_spill_when_full: assert property (@(posedge clk) disable iff (rst)
        go && op_code == 3'd1 && cansave == '0
        |=> trap_valid && trap_type[8:6] == 3'b010 && $stable(cwp_sw));

    a_r3_clean_window: assert property (@(posedge clk) disable iff (rst)
        go && op_code == 3'd1 && cansave != '0 && cleanwin == canrestore
        |=> trap_valid && trap_type == 9'h024 && $stable(cansave));

    a_r4_save_moves_ptr: assert property (@(posedge clk) disable iff (rst)
        go && op_code == 3'd1 && cansave != '0 && cleanwin != canrestore
        |=> !trap_valid && cwp_sw == (($past(cwp_sw) == LAST) ? '0 : CW'($past(cwp_sw) + 1'b1)));

    a_r5_fill_when_empty: assert property (@(posedge clk) disable iff (rst)
        go && op_code == 3'd2 && canrestore == '0
        |=> trap_valid && trap_type[8:6] == 3'b011 && $stable(cwp_sw));

    a_r8_saved_frees: assert property (@(posedge clk) disable iff (rst)
        go && op_code == 3'd4
        |=> cansave == CW'($past(cansave) + 1'b1));

    a_r11_no_spurious_trap: assert property (@(posedge clk) disable iff (rst)
        !go |=> !trap_valid);
endmodule

bind win_state_unit wsu_checker #(.NWIN(NWIN)) u_chk (.*);

// File: tb/win_state_unit_bench.sv
module win_state_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] cansave, canrestore, otherwin, cleanwin, cwp_sw;
    logic [5:0] wstate;
    logic       trap_valid;
    logic [8:0] trap_type;

    int applied = 0;
    int misses  = 0;

    always #5 clk = ~clk;

    win_state_unit u_win_state_unit (.*);

    typedef struct packed {
        logic       is_wr;
        logic [2:0] code;
        logic [7:0] data;
        logic [3:0] req;
        logic [2:0] cs, cr, ow, cw;
        logic [5:0] ws;
        logic [2:0] cwp;
        logic       tv;
        logic [8:0] tt;
    } vec_t;

    localparam int NV = 30;
    // Expected: free, reach, foreign, clean, selector, visible ptr, trap flag, type (N = 8)
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd3, 8'd0,  4'd7,  3'd6, 3'd0, 3'd0, 3'd7, 6'h00, 3'd7, 1'b0, 9'h000}, // R7 flush ok
        '{1'b0, 3'd2, 8'd0,  4'd5,  3'd6, 3'd0, 3'd0, 3'd7, 6'h00, 3'd7, 1'b1, 9'h0C0}, // R5 fill
        '{1'b0, 3'd1, 8'd0,  4'd4,  3'd5, 3'd1, 3'd0, 3'd7, 6'h00, 3'd0, 1'b0, 9'h000}, // R4 save wrap 7->0
        '{1'b0, 3'd1, 8'd0,  4'd4,  3'd4, 3'd2, 3'd0, 3'd7, 6'h00, 3'd1, 1'b0, 9'h000}, // R4
        '{1'b0, 3'd3, 8'd0,  4'd7,  3'd4, 3'd2, 3'd0, 3'd7, 6'h00, 3'd1, 1'b1, 9'h080}, // R7 flush spill
        '{1'b1, 3'd4, 8'h1A, 4'd10, 3'd4, 3'd2, 3'd0, 3'd7, 6'h1A, 3'd1, 1'b0, 9'h000}, // R10 selector
        '{1'b0, 3'd3, 8'd0,  4'd6,  3'd4, 3'd2, 3'd0, 3'd7, 6'h1A, 3'd1, 1'b1, 9'h088}, // R6 normal field
        '{1'b1, 3'd2, 8'd2,  4'd10, 3'd4, 3'd2, 3'd2, 3'd7, 6'h1A, 3'd1, 1'b0, 9'h000}, // R10 foreign
        '{1'b0, 3'd3, 8'd0,  4'd6,  3'd4, 3'd2, 3'd2, 3'd7, 6'h1A, 3'd1, 1'b1, 9'h0AC}, // R6 foreign field
        '{1'b0, 3'd4, 8'd0,  4'd8,  3'd5, 3'd2, 3'd1, 3'd7, 6'h1A, 3'd1, 1'b0, 9'h000}, // R8 foreign path
        '{1'b0, 3'd5, 8'd0,  4'd9,  3'd5, 3'd3, 3'd0, 3'd7, 6'h1A, 3'd1, 1'b0, 9'h000}, // R9 clean saturates
        '{1'b0, 3'd4, 8'd0,  4'd8,  3'd6, 3'd2, 3'd0, 3'd7, 6'h1A, 3'd1, 1'b0, 9'h000}, // R8 reach path
        '{1'b1, 3'd3, 8'd3,  4'd10, 3'd6, 3'd2, 3'd0, 3'd3, 6'h1A, 3'd1, 1'b0, 9'h000}, // R10 clean
        '{1'b0, 3'd1, 8'd0,  4'd4,  3'd5, 3'd3, 3'd0, 3'd3, 6'h1A, 3'd2, 1'b0, 9'h000}, // R4
        '{1'b0, 3'd1, 8'd0,  4'd3,  3'd5, 3'd3, 3'd0, 3'd3, 6'h1A, 3'd2, 1'b1, 9'h024}, // R3 clean trap
        '{1'b0, 3'd5, 8'd0,  4'd9,  3'd4, 3'd4, 3'd0, 3'd4, 6'h1A, 3'd2, 1'b0, 9'h000}, // R9 clean grows
        '{1'b0, 3'd2, 8'd0,  4'd5,  3'd5, 3'd3, 3'd0, 3'd4, 6'h1A, 3'd1, 1'b0, 9'h000}, // R5 restore
        '{1'b1, 3'd0, 8'd0,  4'd10, 3'd0, 3'd3, 3'd0, 3'd4, 6'h1A, 3'd1, 1'b0, 9'h000}, // R10 free
        '{1'b0, 3'd1, 8'd0,  4'd2,  3'd0, 3'd3, 3'd0, 3'd4, 6'h1A, 3'd1, 1'b1, 9'h088}, // R2 spill
        '{1'b1, 3'd1, 8'd0,  4'd10, 3'd0, 3'd0, 3'd0, 3'd4, 6'h1A, 3'd1, 1'b0, 9'h000}, // R10 reach
        '{1'b1, 3'd2, 8'd1,  4'd10, 3'd0, 3'd0, 3'd1, 3'd4, 6'h1A, 3'd1, 1'b0, 9'h000}, // R10
        '{1'b0, 3'd2, 8'd0,  4'd6,  3'd0, 3'd0, 3'd1, 3'd4, 6'h1A, 3'd1, 1'b1, 9'h0EC}, // R6 fill foreign
        '{1'b1, 3'd5, 8'd3,  4'd10, 3'd0, 3'd0, 3'd1, 3'd4, 6'h1A, 3'd3, 1'b0, 9'h000}, // R10 pointer
        '{1'b1, 3'd5, 8'd13, 4'd10, 3'd0, 3'd0, 3'd1, 3'd4, 6'h1A, 3'd5, 1'b0, 9'h000}, // R10 modulo
        '{1'b0, 3'd5, 8'd0,  4'd9,  3'd0, 3'd1, 3'd0, 3'd5, 6'h1A, 3'd5, 1'b0, 9'h000}, // R9 foreign path
        '{1'b0, 3'd2, 8'd0,  4'd5,  3'd1, 3'd0, 3'd0, 3'd5, 6'h1A, 3'd4, 1'b0, 9'h000}, // R5
        '{1'b1, 3'd5, 8'd7,  4'd10, 3'd1, 3'd0, 3'd0, 3'd5, 6'h1A, 3'd7, 1'b0, 9'h000}, // R10
        '{1'b0, 3'd1, 8'd0,  4'd4,  3'd0, 3'd1, 3'd0, 3'd5, 6'h1A, 3'd0, 1'b0, 9'h000}, // R4 wrap
        '{1'b0, 3'd2, 8'd0,  4'd5,  3'd1, 3'd0, 3'd0, 3'd5, 6'h1A, 3'd7, 1'b0, 9'h000}, // R5 wrap 0->7
        '{1'b0, 3'd0, 8'd0,  4'd11, 3'd1, 3'd0, 3'd0, 3'd5, 6'h1A, 3'd7, 1'b0, 9'h000}  // R11 idle
    };

    task automatic compare(input vec_t v, input int idx);
        logic [35:0] got, exp;
        got = {cansave, canrestore, otherwin, cleanwin, wstate, cwp_sw, trap_valid, trap_type};
        exp = {v.cs, v.cr, v.ow, v.cw, v.ws, v.cwp, v.tv, v.tt};
        applied++;
        if (got !== exp) begin
            misses++;
            $display("FAIL R%0d step %0d: got %h expected %h", v.req, idx, got, exp);
        end
    endtask

    task automatic step(input vec_t v, input int idx);
        op_valid = !v.is_wr;
        op_code  = v.code;
        wr_en    = v.is_wr;
        wr_sel   = v.code;
        wr_data  = v.data;
        @(negedge clk);
        op_valid = 1'b0;
        wr_en    = 1'b0;
        compare(v, idx);
    endtask

    localparam vec_t RST_EXP = '{1'b0, 3'd0, 8'd0, 4'd1, 3'd6, 3'd0, 3'd0, 3'd7, 6'h00, 3'd7, 1'b0, 9'h000};

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        compare(RST_EXP, -1); // R1 reset state
        for (int i = 0; i < NV; i++) step(VEC[i], i);

        // R11: write and operation together, only the write lands (restore would fill)
        step('{1'b1, 3'd0, 8'd3, 4'd11, 3'd3, 3'd0, 3'd0, 3'd5, 6'h1A, 3'd7, 1'b0, 9'h000}, 100);
        op_valid = 1'b1; op_code = 3'd2; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'd2;
        @(negedge clk);
        op_valid = 1'b0; wr_en = 1'b0;
        compare('{1'b1, 3'd0, 8'd2, 4'd11, 3'd2, 3'd0, 3'd0, 3'd5, 6'h1A, 3'd7, 1'b0, 9'h000}, 101);

        // R1: reset mid-run restores every value
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        compare(RST_EXP, 102);
        summary();
    end
endmodule